// File: doc/BRIEF.md
# Output Power Sequencing Controller

This block steers the analog output stage of a stereo converter so that power-up and power-down happen without audible clicks. Out of reset it keeps both outputs clamped to ground for a fixed number of sample periods. It then drives a rising ramp code that moves the output bias toward its quiescent level over a much longer span. Audio is released only after the ramp has finished.

Sample periods are counted from a one-cycle sample strobe. Counting stops while the strobe is absent. If the clock monitor flags that the master or frame clock has gone, the block leaves any state at once. It then disconnects the output buffers and switches in a slow discharge sink. It stays there until the clocks return, and then restarts the full clamp and ramp sequence from the beginning. The analog circuits themselves sit outside this block.

Top module: `outpwr_seq`

## Requirements
- R1: After reset, `clamp_en`=1, `buf_connect`=1, `sink_en`=0, `audio_en`=0 and `ramp_code`=0.
- R2: The clamp phase lasts exactly CLAMP_PERIODS strobes. The cycle after the CLAMP_PERIODS-th strobe edge shows `clamp_en`=0 and `ramp_code`=0.
- R3: During the ramp phase, `ramp_code` starts at 0 and rises by exactly one on each strobe.
- R4: After RAMP_PERIODS ramp strobes, `ramp_code` equals RAMP_PERIODS (full scale) and `audio_en`=1. Both hold while the clocks stay present.
- R5: While `sample_tick` is low and `clk_lost` is low, `ramp_code` and `audio_en` do not change.
- R6: `clk_lost` high at an edge gives, from the next cycle on, `buf_connect`=0, `sink_en`=1, `audio_en`=0, `clamp_en`=0 and `ramp_code`=0. This is the same in every state, and it holds for as long as `clk_lost` stays high.
- R7: When `clk_lost` and `sample_tick` are high in the same cycle, the loss wins, even on the strobe that would end the clamp or ramp phase.
- R8: In power-down, the first edge with `clk_lost` low returns the block to clamp with the count cleared. A full CLAMP_PERIODS strobes are then needed again.
- R9: `audio_en` and `clamp_en` are never high together. `sink_en` and `buf_connect` are never high together.
- R10: Strobes received while audio runs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-cycle strobe per sample period |
| clk_lost | input | 1 | High while the master or frame clock is missing |
| clamp_en | output | 1 | Clamp outputs to analog ground |
| ramp_code | output | RAMP_W | Bias ramp target code |
| buf_connect | output | 1 | Connect output buffers to pins |
| sink_en | output | 1 | Enable slow discharge sink |
| audio_en | output | 1 | Pass audio samples to outputs |

## Verification
Two events can land on the same edge: a clock loss, and the strobe that would end the clamp or the ramp phase. The bench reaches them on purpose. It steps the clamp or ramp count to its last value and then raises `clk_lost` together with `sample_tick`. The bench then expects power-down outputs with a cleared code on the next cycle, and no transition to the next phase. Random stimulus also produces such overlaps at other counts, and each cycle is compared against a reference model in the bench.

// File: rtl/outpwr_seq.sv
module outpwr_seq #(
  parameter int CLAMP_PERIODS = 1000,
  parameter int RAMP_PERIODS  = 10000,
  parameter int RAMP_W        = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_tick,
  input  logic              clk_lost,
  output logic              clamp_en,
  output logic [RAMP_W-1:0] ramp_code,
  output logic              buf_connect,
  output logic              sink_en,
  output logic              audio_en
);
  localparam int MAXP  = (CLAMP_PERIODS > RAMP_PERIODS) ? CLAMP_PERIODS : RAMP_PERIODS;
  localparam int CNT_W = $clog2(MAXP + 1);
  localparam logic [CNT_W-1:0] CL_LAST = CNT_W'(CLAMP_PERIODS - 1);
  localparam logic [CNT_W-1:0] RP_LAST = CNT_W'(RAMP_PERIODS - 1);
  localparam logic [RAMP_W-1:0] FULL   = RAMP_W'(RAMP_PERIODS);

  typedef enum logic [1:0] {S_CLAMP, S_RAMP, S_RUN, S_DOWN} st_t;

  st_t             st, st_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    if (clk_lost) begin
      st_nx  = S_DOWN;
      cnt_nx = '0;
    end else begin
      unique case (st)
        S_DOWN: begin
          st_nx  = S_CLAMP;
          cnt_nx = '0;
        end
        S_CLAMP: if (sample_tick) begin
          if (cnt == CL_LAST) begin
            st_nx  = S_RAMP;
            cnt_nx = '0;
          end else cnt_nx = cnt + 1'b1;
        end
        S_RAMP: if (sample_tick) begin
          if (cnt == RP_LAST) begin
            st_nx  = S_RUN;
            cnt_nx = '0;
          end else cnt_nx = cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= S_CLAMP;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
    end

  assign clamp_en    = (st == S_CLAMP);
  assign audio_en    = (st == S_RUN);
  assign sink_en     = (st == S_DOWN);
  assign buf_connect = (st != S_DOWN);
  assign ramp_code   = (st == S_RAMP) ? RAMP_W'(cnt) :
                       (st == S_RUN)  ? FULL : '0;
endmodule

// File: rtl/outpwr_seq_chk.sv
module outpwr_seq_chk #(
  parameter int RAMP_W = 14,
  parameter int FULL   = 10000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_tick,
  input logic              clk_lost,
  input logic              clamp_en,
  input logic [RAMP_W-1:0] ramp_code,
  input logic              buf_connect,
  input logic              sink_en,
  input logic              audio_en
);
  // R9
  excl_audio_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(audio_en && clamp_en));
  // R9
  excl_sink_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sink_en && buf_connect));
  // R6
  loss_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_lost |=> (sink_en && !buf_connect && !audio_en && !clamp_en && ramp_code == '0));
  // R5
  pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_tick && !clk_lost) |=> ($stable(ramp_code) && $stable(audio_en)));
  // R3
  ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && !clk_lost && buf_connect && !clamp_en && !audio_en)
      |=> (ramp_code == $past(ramp_code) + 1'b1));
  // R4
  run_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    audio_en |-> (ramp_code == RAMP_W'(FULL)));
  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sink_en && !clk_lost) |=> (clamp_en && buf_connect && ramp_code == '0));
endmodule

bind outpwr_seq outpwr_seq_chk #(.RAMP_W(RAMP_W), .FULL(RAMP_PERIODS)) i_chk (.*);

// File: tb/test_outpwr_seq.sv
module test_outpwr_seq;
  localparam int CL = 12;
  localparam int RP = 40;
  localparam int RW = 14;

  logic clk = 1'b0, rst_n = 1'b0, sample_tick = 1'b0, clk_lost = 1'b0;
  logic clamp_en, buf_connect, sink_en, audio_en;
  logic [RW-1:0] ramp_code;

  int checks = 0, fails = 0;
  int m_st = 0, m_cnt = 0;   // 0 clamp, 1 ramp, 2 run, 3 down

  always #10 clk = ~clk;

  outpwr_seq #(.CLAMP_PERIODS(CL), .RAMP_PERIODS(RP), .RAMP_W(RW)) i_outpwr_seq (.*);

  function automatic int exp_ramp(int st, int c);
    return (st == 1) ? c : (st == 2) ? RP : 0;
  endfunction

  task automatic chk1(string req, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", req, nm, act, exp, $time);
    end
  endtask

  task automatic check_all(string req);
    chk1(req, "clamp_en", int'(clamp_en), int'(m_st == 0));
    chk1(req, "audio_en", int'(audio_en), int'(m_st == 2));
    chk1(req, "sink_en", int'(sink_en), int'(m_st == 3));
    chk1(req, "buf_connect", int'(buf_connect), int'(m_st != 3));
    chk1(req, "ramp_code", int'(ramp_code), exp_ramp(m_st, m_cnt));
    chk1("R9", "exclusive", int'((audio_en && clamp_en) || (sink_en && buf_connect)), 0);
  endtask

  task automatic model_step(logic t, logic l);
    if (l) begin m_st = 3; m_cnt = 0; end
    else case (m_st)
      3: begin m_st = 0; m_cnt = 0; end
      0: if (t) begin if (m_cnt == CL-1) begin m_st = 1; m_cnt = 0; end else m_cnt++; end
      1: if (t) begin if (m_cnt == RP-1) begin m_st = 2; m_cnt = 0; end else m_cnt++; end
      default: ;
    endcase
  endtask

  // drive at negedge, check result at following negedge
  task automatic step(logic t, logic l, string req);
    @(negedge clk);
    check_all(req);
    sample_tick = t;
    clk_lost    = l;
    model_step(t, l);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lost_left;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1");
    // R2 R3 R4: directed full sequence, strobe every cycle
    while (m_st != 2) step(1'b1, 1'b0, (m_st == 0) ? "R2" : "R3");
    // R10: strobes during run
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, "R10");
    // R5: no strobes
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, "R5");
    // R6: loss during run, held
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, "R6");
    // R8: return, then loss on final clamp strobe (R7)
    step(1'b0, 1'b0, "R8");
    while (!(m_st == 0 && m_cnt == CL-1)) step(1'b1, 1'b0, "R8");
    step(1'b1, 1'b1, "R7");
    step(1'b0, 1'b0, "R7");
    // loss on final ramp strobe
    while (!(m_st == 1 && m_cnt == RP-1)) step(1'b1, 1'b0, "R3");
    step(1'b1, 1'b1, "R7");
    step(1'b0, 1'b0, "R8");
    // random mix
    lost_left = 0;
    for (int i = 0; i < 8000; i++) begin
      logic t, l;
      if (lost_left == 0 && ($urandom % 300) == 0) lost_left = 1 + ($urandom % 5);
      l = (lost_left != 0);
      if (lost_left != 0) lost_left--;
      t = (($urandom % 3) == 0);
      step(t, l, l ? "R6" : (t ? "R3" : "R5"));
    end
    step(1'b0, 1'b0, "R4");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule